// File: doc/BRIEF.md
# Class-Selected Multifunction ALU

This block is the combinational arithmetic and logic unit of a small single-cycle processor. It takes two operands and produces one result word plus a zero flag. Operand B arrives already chosen, either a register value or an extended immediate.

Four small units work in parallel on the same operands:

- an upper-immediate placer;
- a signed set-less-than unit;
- an adder/subtractor;
- a bitwise logic unit.

A 2-bit class select picks which unit drives the result. Two of the units have their own sub-control. The adder takes a 1-bit subtract select, and the logic unit takes a 2-bit function select. The decoder therefore sets a few independent fields rather than one flat operation code.

Addition and subtraction share one adder. Subtraction is formed as A plus the inverted B plus one. The signed comparison reads the sign of that difference and corrects it with the overflow bit. This is why set-less-than must be issued with the subtract select asserted.

Top module: `class_sel_alu`

## Requirements
- R1: The class select `fclass` picks the result source: 2'b00 upper-immediate, 2'b01 set-less-than, 2'b10 add/subtract, 2'b11 bitwise logic.
- R2: With `fclass`=2'b10 and `sub_sel`=0, `result` is `opa + opb` modulo 2^32, wrapping silently on overflow.
- R3: With `fclass`=2'b10 and `sub_sel`=1, `result` is `opa - opb` modulo 2^32, wrapping silently on overflow.
- R4: With `fclass`=2'b11, `lfn` selects the bitwise function: 2'b00 AND, 2'b01 OR, 2'b10 XOR, 2'b11 NOR.
- R5: With `fclass`=2'b00, `result` is `opb[15:0]` placed in bits 31:16 with bits 15:0 zero; `opa` and `opb[31:16]` have no effect.
- R6: With `fclass`=2'b01 and `sub_sel`=1, `result` is 32'd1 when `opa` < `opb` as two's-complement signed numbers, else 32'd0, including operand pairs whose difference overflows.
- R7: `zero` is 1 exactly when all 32 bits of `result` are 0.
- R8: In the upper-immediate and logic classes, `sub_sel` has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | Operand A (register value) |
| opb | input | 32 | Operand B (register or extended immediate) |
| fclass | input | 2 | Function class select |
| sub_sel | input | 1 | 0 add, 1 subtract |
| lfn | input | 2 | Logic function select |
| result | output | 32 | Selected unit output |
| zero | output | 1 | High when result is all zeros |

## Verification
The assertions assume that the set-less-than class is only presented with `sub_sel` high. With `sub_sel` low, the comparison unit sees a sum rather than a difference, and its output has no defined meaning. Every set-less-than check in the assertions is therefore gated on `sub_sel`.

The random stimulus forces `sub_sel` to 1 whenever it draws the set-less-than class, and all directed comparison vectors do the same. The checks also skip any evaluation where an input is still unknown, so the values before the bench first drives the ports are never judged.

// File: rtl/class_sel_alu.sv
module class_sel_alu #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [1:0]       fclass,
  input  logic             sub_sel,
  input  logic [1:0]       lfn,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  localparam int LO_W = WIDTH - IMM_W;
  localparam int MSB  = WIDTH - 1;

  logic [WIDTH-1:0] b_eff, sum, lui_out, slt_out, logic_out;
  logic             ovf, less;

  // shared adder: subtraction as A + ~B + 1
  assign b_eff = sub_sel ? ~opb : opb;
  assign sum   = opa + b_eff + {{(WIDTH-1){1'b0}}, sub_sel};

  // signed overflow of the adder, used to correct the sign for comparison
  assign ovf  = (opa[MSB] == b_eff[MSB]) && (sum[MSB] != opa[MSB]);
  assign less = sum[MSB] ^ ovf;

  assign lui_out = {opb[IMM_W-1:0], {LO_W{1'b0}}};
  assign slt_out = {{(WIDTH-1){1'b0}}, less};

  always_comb begin
    case (lfn)
      2'b00:   logic_out = opa & opb;
      2'b01:   logic_out = opa | opb;
      2'b10:   logic_out = opa ^ opb;
      default: logic_out = ~(opa | opb);
    endcase
  end

  always_comb begin
    case (fclass)
      2'b00:   result = lui_out;
      2'b01:   result = slt_out;
      2'b10:   result = sum;
      default: result = logic_out;
    endcase
  end

  assign zero = ~|result;
endmodule

// File: rtl/class_sel_alu_chk.sv
module class_sel_alu_chk #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [1:0]       fclass,
  input logic             sub_sel,
  input logic [1:0]       lfn,
  input logic [WIDTH-1:0] result,
  input logic             zero
);
  localparam int LO_W = WIDTH - IMM_W;

  logic known;
  assign known = !$isunknown({opa, opb, fclass, sub_sel, lfn, result, zero});

  always_comb begin
    if (known) begin
      if (fclass == 2'b10 && !sub_sel)
        a_r2_add_inverse: assert (result - opb == opa) else $error("R2 add inverse");
      if (fclass == 2'b10 && sub_sel)
        a_r3_sub_inverse: assert (result + opb == opa) else $error("R3 sub inverse");
      if (fclass == 2'b01 && sub_sel)
        a_r6_slt_signed: assert (result == {{(WIDTH-1){1'b0}}, ($signed(opa) < $signed(opb))})
          else $error("R6 slt");
      if (fclass == 2'b00)
        a_r5_lui_low_clear: assert (result[LO_W-1:0] == '0 && result[WIDTH-1:LO_W] == opb[IMM_W-1:0])
          else $error("R5 lui");
      if (fclass == 2'b01)
        a_r1_slt_narrow: assert (result[WIDTH-1:1] == '0) else $error("R1 slt width");
      if (fclass == 2'b11 && lfn == 2'b11)
        a_r4_nor_disjoint: assert ((result & opa) == '0 && (result & opb) == '0)
          else $error("R4 nor");
      if (fclass == 2'b11 && lfn == 2'b00)
        a_r4_and_subset: assert ((result & ~opa) == '0 && (result & ~opb) == '0)
          else $error("R4 and");
      a_r7_zero_flag: assert (!zero || (result[0] == 1'b0 && result[WIDTH-1] == 1'b0))
        else $error("R7 zero");
    end
  end
endmodule

bind class_sel_alu class_sel_alu_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W)) chk (
  .opa(opa), .opb(opb), .fclass(fclass), .sub_sel(sub_sel), .lfn(lfn),
  .result(result), .zero(zero)
);

// File: tb/class_sel_alu_test.sv
module class_sel_alu_test;
  logic        clk = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [1:0]  fclass = 2'b10, lfn = 2'b00;
  logic        sub_sel = 1'b0;
  logic [31:0] result;
  logic        zero;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  class_sel_alu uut (.opa(opa), .opb(opb), .fclass(fclass), .sub_sel(sub_sel),
                     .lfn(lfn), .result(result), .zero(zero));

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [1:0] c, input logic s, input logic [1:0] f);
    case (c)
      2'b00: return {b[15:0], 16'h0000};
      2'b01: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      2'b10: return s ? a - b : a + b;
      default: case (f)
        2'b00: return a & b;
        2'b01: return a | b;
        2'b10: return a ^ b;
        default: return ~(a | b);
      endcase
    endcase
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [1:0] c,
                       input logic s, input logic [1:0] f, input string req);
    logic [31:0] exp;
    @(posedge clk);
    #2;
    opa = a; opb = b; fclass = c; sub_sel = s; lfn = f;
    #2;
    exp = model(a, b, c, s, f);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s result: actual %h expected %h (a=%h b=%h c=%0d s=%0d f=%0d)",
               req, result, exp, a, b, c, s, f);
    end
    checks++;
    if (zero !== (exp == 32'd0)) begin
      fails++;
      $display("FAIL R7 zero: actual %0d expected %0d", zero, exp == 32'd0);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [31:0] r0, r1;
    seed = 32'h1d2c3b4a;
    void'($urandom(seed));
    // initial state: all-zero operands, adder class
    #2;
    checks++;
    if (result !== 32'd0 || zero !== 1'b1) begin
      fails++;
      $display("FAIL R7 initial: actual %h/%0d expected 0/1", result, zero);
    end
    // R2 wrap and R7 zero
    apply(32'hFFFF_FFFF, 32'd1, 2'b10, 1'b0, 2'b00, "R2");
    apply(32'h7FFF_FFFF, 32'd1, 2'b10, 1'b0, 2'b00, "R2");
    // R3 wrap and equality
    apply(32'd0, 32'd1, 2'b10, 1'b1, 2'b00, "R3");
    apply(32'h1234_5678, 32'h1234_5678, 2'b10, 1'b1, 2'b00, "R3");
    apply(32'h8000_0000, 32'd1, 2'b10, 1'b1, 2'b00, "R3");
    // R6 overflow corner cases
    apply(32'h7FFF_FFFF, 32'h8000_0000, 2'b01, 1'b1, 2'b00, "R6");
    apply(32'h8000_0000, 32'h7FFF_FFFF, 2'b01, 1'b1, 2'b00, "R6");
    apply(32'h8000_0000, 32'd1, 2'b01, 1'b1, 2'b00, "R6");
    apply(32'hFFFF_FFFF, 32'd0, 2'b01, 1'b1, 2'b00, "R6");
    apply(32'd5, 32'd5, 2'b01, 1'b1, 2'b00, "R6");
    // R4 all four functions
    for (int f = 0; f < 4; f++)
      apply(32'hF0F0_FF00, 32'hFF00_F0F0, 2'b11, 1'b0, f[1:0], "R4");
    apply(32'hFFFF_FFFF, 32'h0, 2'b11, 1'b0, 2'b11, "R4");
    // R5 upper half, opa and opb[31:16] ignored
    apply(32'hDEAD_BEEF, 32'hABCD_1234, 2'b00, 1'b0, 2'b10, "R5");
    apply(32'h0, 32'hFFFF_0000, 2'b00, 1'b0, 2'b00, "R5");
    // R8 sub_sel ignored in lui and logic classes
    for (int c = 0; c < 2; c++)
      for (int f = 0; f < 4; f++) begin
        r0 = $urandom; r1 = $urandom;
        apply(r0, r1, c[0] ? 2'b11 : 2'b00, 1'b0, f[1:0], "R8");
        apply(r0, r1, c[0] ? 2'b11 : 2'b00, 1'b1, f[1:0], "R8");
      end
    // R1 random mix over all classes
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] c;
      logic s;
      c = 2'($urandom);
      s = 1'($urandom);
      if (c == 2'b01) s = 1'b1;
      r0 = $urandom; r1 = $urandom;
      if (i % 7 == 0) r1 = r0;
      apply(r0, r1, c, s, 2'($urandom), "R1");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule